// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Edge Flags

This block is a first-in first-out buffer that links two free-running clock domains, which may be unrelated in frequency and phase. The producer pushes words on the write clock and sees an input-ready flag. The consumer sees the head word already on the output, in fall-through style, together with an output-ready flag, and pops that word on the read clock. Each side has a pair of enables that must both be high, and the read side also has an output enable. The output enable floats the data outputs and blocks reads.

Read and write pointers pass between the domains as Gray codes through two-stage synchronizers. Each domain therefore sees the other side's progress a little late. This delay can only make the flags cautious: a write is never accepted into a full buffer, and a word is never presented from an empty one.

Two occupancy flags are kept in the write domain. A half-full flag marks the upper half of the buffer. A single "near edge" flag is high when the buffer is nearly empty or nearly full, and one offset sets both margins. After reset, and before the first word is accepted, the offset can be loaded through the data input. During that load, the first write enable carries the most significant offset bit.

Top module: `dcfifo_pf`

## Requirements
- R1: The buffer holds 2^AW words of DW bits (default 2048 x 9). Words leave in the order they were accepted, and with no reads exactly 2^AW words are accepted.
- R2: A word is accepted on a rising write-clock edge only when wen_a, wen_b, prog_n and in_ready are all high. in_ready is low whenever the buffer is full, and a write attempted then is lost.
- R3: A word is popped on a rising read-clock edge only when rd_a, rd_b, oe and out_ready are all high. out_ready is low whenever no word is present, and dropping any one of the three enables leaves the head word in place.
- R4: When a word is written into an empty buffer, it appears on dout and out_ready rises on the third rising read-clock edge after the write edge.
- R5: While out_ready is low, dout (with oe high) keeps the last word popped. While oe is low, dout is high-impedance.
- R6: half_full is high exactly when the occupancy seen by the write side is at least 2^(AW-1). Right after a write edge it already counts that write.
- R7: edge_flag is high when the write-side occupancy is at most K or at least 2^AW - K, where K is the offset. K is DEF_OFS unless it has been programmed.
- R8: rst is synchronous and active high, and must be held for at least four edges of each clock. While it is held, in_ready, out_ready and half_full are low and edge_flag is high.
- R9: in_ready stays low on the first write-clock edge after rst falls and goes high on the second.
- R10: After reset and before the first accepted write, each write-clock edge with prog_n low loads K from {wen_a, din}, with wen_a as the most significant bit. No write happens while prog_n is low. Once a word has been accepted, K can no longer be changed.
- R11: Write-side flags learn of reads only after the pointer has been synchronized. After the first pop from a full buffer, in_ready stays low on the next write-clock edge and is high by the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock, free running |
| rclk | input | 1 | Read clock, free running |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| din | input | DW | Write data; also low offset bits while programming |
| wen_a | input | 1 | Write enable A; offset MSB while programming |
| wen_b | input | 1 | Write enable B |
| prog_n | input | 1 | Active-low offset load strobe |
| in_ready | output | 1 | High when a write would be accepted |
| rd_a | input | 1 | Read enable A |
| rd_b | input | 1 | Read enable B |
| oe | input | 1 | Output enable; low floats dout and blocks reads |
| out_ready | output | 1 | High when dout carries a valid head word |
| dout | output | DW | Head word, or high-impedance when oe is low |
| half_full | output | 1 | Occupancy at least half of capacity |
| edge_flag | output | 1 | Occupancy within K of empty or of full |

## Verification
A corrupted fetch pointer or RAM output register shows at dout on the very next pop, as a word out of order or a duplicate. A wrong Gray conversion or synchronizer stage moves the out_ready rise away from the third read edge and the in_ready recovery away from the expected write edges, so it is visible within four cycles. A wrong occupancy count or a wrong offset appears as a half_full or edge_flag mismatch on the write edge that carries the faulty count. A sweep of every fill level of a 16-word configuration therefore exposes it at the first occupancy where the thresholds disagree.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  // write-side wake sequence after reset release
  typedef enum logic {
    WK_HOLD = 1'b0,
    WK_RUN  = 1'b1
  } wake_e;
endpackage

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int DW = 9,
  parameter int AW = 11
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port doubles as the fall-through output register
  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[i] <= '0;
        else     st[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[i] <= '0;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/dcf_wside.sv
`timescale 1ns/1ps
module dcf_wside
  import dcf_pkg::*;
#(
  parameter int DW      = 9,
  parameter int AW      = 11,
  parameter int DEF_OFS = 256
) (
  input  logic          wclk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          wen_a,
  input  logic          wen_b,
  input  logic          prog_n,
  input  logic [AW:0]   cgray_s,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          wr_fire,
  output logic          in_ready,
  output logic          half_full,
  output logic          edge_flag
);
  localparam int OW = DW + 1;
  localparam logic [AW:0]   FULL_CNT = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0]   HALF_CNT = {2'b01, {(AW-1){1'b0}}};
  localparam logic [OW-1:0] OFS_RST  = OW'(DEF_OFS);

  wake_e         wake_q;
  logic [AW:0]   wbin_q, wbin_nx, cbin, occ_nx;
  logic [OW-1:0] ofs_q;
  logic          open_q;
  logic [31:0]   occ_w, ofs_w;
  logic          near_nx;

  // Gray to binary for the synchronized consumed pointer
  for (genvar i = 0; i <= AW; i++) begin : g_g2b
    assign cbin[i] = ^cgray_s[AW:i];
  end

  assign wr_fire = wen_a & wen_b & prog_n & in_ready;
  assign wbin_nx = wbin_q + {{AW{1'b0}}, wr_fire};
  assign occ_nx  = wbin_nx - cbin;
  assign occ_w   = 32'(occ_nx);
  assign ofs_w   = 32'(ofs_q);
  assign near_nx = (occ_w <= ofs_w) || (occ_w + ofs_w >= 32'(FULL_CNT));
  assign waddr   = wbin_q[AW-1:0];

  always_ff @(posedge wclk) begin
    if (rst) begin
      wake_q    <= WK_HOLD;
      wbin_q    <= '0;
      wgray     <= '0;
      in_ready  <= 1'b0;
      half_full <= 1'b0;
      edge_flag <= 1'b1;
      ofs_q     <= OFS_RST;
      open_q    <= 1'b1;
    end else begin
      wake_q    <= WK_RUN;
      wbin_q    <= wbin_nx;
      wgray     <= wbin_nx ^ (wbin_nx >> 1);
      in_ready  <= (wake_q == WK_RUN) && (occ_nx != FULL_CNT);
      half_full <= (occ_nx >= HALF_CNT);
      edge_flag <= near_nx;
      if (open_q && !prog_n) ofs_q  <= {wen_a, din};
      if (wr_fire)           open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dcf_rside.sv
`timescale 1ns/1ps
module dcf_rside #(
  parameter int AW = 11
) (
  input  logic          rclk,
  input  logic          rst,
  input  logic          rd_a,
  input  logic          rd_b,
  input  logic          oe,
  input  logic [AW:0]   wgray_s,
  output logic [AW-1:0] raddr,
  output logic          fetch,
  output logic [AW:0]   cgray,
  output logic          out_ready
);
  logic [AW:0] fbin_q, fgray_q, fbin_nx;
  logic [AW:0] cbin_q, cbin_nx;
  logic        rd_fire, has_word;

  assign rd_fire  = rd_a & rd_b & oe & out_ready;
  assign has_word = (fgray_q != wgray_s);
  assign fetch    = (!out_ready || rd_fire) && has_word;
  assign fbin_nx  = fbin_q + {{AW{1'b0}}, 1'b1};
  assign cbin_nx  = cbin_q + {{AW{1'b0}}, 1'b1};
  assign raddr    = fbin_q[AW-1:0];

  always_ff @(posedge rclk) begin
    if (rst) begin
      fbin_q    <= '0;
      fgray_q   <= '0;
      cbin_q    <= '0;
      cgray     <= '0;
      out_ready <= 1'b0;
    end else begin
      if (fetch) begin
        fbin_q    <= fbin_nx;
        fgray_q   <= fbin_nx ^ (fbin_nx >> 1);
        out_ready <= 1'b1;
      end else if (rd_fire) begin
        out_ready <= 1'b0;
      end
      if (rd_fire) begin
        cbin_q <= cbin_nx;
        cgray  <= cbin_nx ^ (cbin_nx >> 1);
      end
    end
  end
endmodule

// File: rtl/dcfifo_pf.sv
`timescale 1ns/1ps
module dcfifo_pf #(
  parameter int DW          = 9,
  parameter int AW          = 11,
  parameter int DEF_OFS     = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          wen_a,
  input  logic          wen_b,
  input  logic          prog_n,
  output logic          in_ready,
  input  logic          rd_a,
  input  logic          rd_b,
  input  logic          oe,
  output logic          out_ready,
  output logic [DW-1:0] dout,
  output logic          half_full,
  output logic          edge_flag
);
  logic [AW:0]   wgray, wgray_r, cgray, cgray_w;
  logic [AW-1:0] waddr, raddr;
  logic          wr_fire, fetch;
  logic [DW-1:0] q_word;

  dcf_wside #(.DW(DW), .AW(AW), .DEF_OFS(DEF_OFS)) u_ws (
    .wclk(wclk), .rst(rst), .din(din), .wen_a(wen_a), .wen_b(wen_b),
    .prog_n(prog_n), .cgray_s(cgray_w), .wgray(wgray), .waddr(waddr),
    .wr_fire(wr_fire), .in_ready(in_ready), .half_full(half_full),
    .edge_flag(edge_flag)
  );

  dcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst(rst), .d(wgray), .q(wgray_r)
  );

  dcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst(rst), .d(cgray), .q(cgray_w)
  );

  dcf_rside #(.AW(AW)) u_rs (
    .rclk(rclk), .rst(rst), .rd_a(rd_a), .rd_b(rd_b), .oe(oe),
    .wgray_s(wgray_r), .raddr(raddr), .fetch(fetch), .cgray(cgray),
    .out_ready(out_ready)
  );

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(din),
    .rclk(rclk), .re(fetch), .raddr(raddr), .rdata(q_word)
  );

  assign dout = oe ? q_word : {DW{1'bz}};
endmodule

// File: rtl/dcfifo_pf_chk.sv
`timescale 1ns/1ps
module dcfifo_pf_chk #(
  parameter int DW = 9,
  parameter int AW = 11
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst,
  input logic          wen_a,
  input logic          wen_b,
  input logic          prog_n,
  input logic          rd_a,
  input logic          rd_b,
  input logic          oe,
  input logic          in_ready,
  input logic          out_ready,
  input logic          half_full,
  input logic          edge_flag,
  input logic [DW-1:0] q_word
);
  localparam int DEPTH = 1 << AW;

  int wr_total, rd_total;

  always_ff @(posedge wclk) begin
    if (rst) begin
      wr_total <= 0;
    end else if (wen_a && wen_b && prog_n && in_ready) begin
      p_no_overflow_r2: assert (wr_total - rd_total < DEPTH)
        else $error("write accepted into a full buffer");
      wr_total <= wr_total + 1;
    end
  end

  always_ff @(posedge rclk) begin
    if (rst) begin
      rd_total <= 0;
    end else if (rd_a && rd_b && oe && out_ready) begin
      p_no_underflow_r3: assert (rd_total < wr_total)
        else $error("pop from an empty buffer");
      rd_total <= rd_total + 1;
    end
  end

  p_rst_wflags_r8: assert property (@(posedge wclk)
    rst |=> (!in_ready && !half_full && edge_flag));

  p_rst_rflag_r8: assert property (@(posedge rclk)
    rst |=> !out_ready);

  p_wake_late_r9: assert property (@(posedge wclk) disable iff (rst)
    $fell(rst) |=> !in_ready);

  p_hold_word_r5: assert property (@(posedge rclk) disable iff (rst)
    !out_ready |=> (out_ready || $stable(q_word)));

  p_full_is_half_r6: assert property (@(posedge wclk) disable iff (rst)
    $fell(in_ready) |-> half_full);
endmodule

bind dcfifo_pf dcfifo_pf_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .wen_a(wen_a), .wen_b(wen_b),
  .prog_n(prog_n), .rd_a(rd_a), .rd_b(rd_b), .oe(oe), .in_ready(in_ready),
  .out_ready(out_ready), .half_full(half_full), .edge_flag(edge_flag),
  .q_word(q_word)
);

// File: tb/sim_dcfifo_pf.sv
`timescale 1ns/1ps
module sim_dcfifo_pf;
  localparam int DW = 4;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int KDEF = 3;

  logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
  logic [DW-1:0] din = '0;
  logic wen_a = 1'b0, wen_b = 1'b0, prog_n = 1'b1;
  logic rd_a = 1'b0, rd_b = 1'b1, oe = 1'b1;
  logic in_ready, out_ready, half_full, edge_flag;
  logic [DW-1:0] dout;

  int rhalf = 2;
  int checks = 0;
  int fails = 0;
  logic [DW-1:0] mq [$];

  always #2 wclk = ~wclk;
  always #(rhalf) rclk = ~rclk;

  dcfifo_pf #(.DW(DW), .AW(AW), .DEF_OFS(KDEF), .SYNC_STAGES(2)) u0 (
    .wclk(wclk), .rclk(rclk), .rst(rst), .din(din), .wen_a(wen_a),
    .wen_b(wen_b), .prog_n(prog_n), .in_ready(in_ready), .rd_a(rd_a),
    .rd_b(rd_b), .oe(oe), .out_ready(out_ready), .dout(dout),
    .half_full(half_full), .edge_flag(edge_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int n);
    return DW'((n * 5 + 1) & 15);
  endfunction

  function automatic bit near(input int n, input int k);
    return (n <= k) || (n + k >= DEPTH);
  endfunction

  task automatic do_reset(input bit check_hold);
    rst = 1'b1; wen_a = 0; wen_b = 0; prog_n = 1; rd_a = 0; rd_b = 1; oe = 1;
    repeat (5) @(posedge wclk);
    repeat (5) @(posedge rclk);
    @(posedge wclk); #1;
    if (check_hold) begin
      chk(in_ready == 0,  "R8 in_ready in reset", in_ready, 0);
      chk(out_ready == 0, "R8 out_ready in reset", out_ready, 0);
      chk(half_full == 0, "R8 half_full in reset", half_full, 0);
      chk(edge_flag == 1, "R8 edge_flag in reset", edge_flag, 1);
    end
    rst = 1'b0;
    @(posedge wclk); #1;
    if (check_hold) chk(in_ready == 0, "R9 in_ready first edge", in_ready, 0);
    @(posedge wclk); #1;
    if (check_hold) chk(in_ready == 1, "R9 in_ready second edge", in_ready, 1);
  endtask

  task automatic push(input logic [DW-1:0] d, output bit acc);
    din = d; wen_a = 1; wen_b = 1;
    acc = in_ready;
    @(posedge wclk); #1;
    wen_a = 0; wen_b = 0;
  endtask

  task automatic pull();
    rd_a = 1;
    @(posedge rclk); #1;
    rd_a = 0;
  endtask

  task automatic program_ofs(input logic msb, input logic [DW-1:0] low);
    prog_n = 0; wen_a = msb; wen_b = 1; din = low;
    @(posedge wclk); #1;
    prog_n = 1; wen_a = 0; wen_b = 0;
  endtask

  initial begin : watchdog
    #600000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    bit acc;
    // reset behaviour, wake sequence
    do_reset(1'b1);

    // first word latency into empty buffer, aligned clocks
    push(4'hA, acc);
    for (int e = 1; e <= 2; e++) begin
      @(posedge rclk); #1;
      chk(out_ready == 0, "R4 out_ready before third edge", out_ready, 0);
    end
    @(posedge rclk); #1;
    chk(out_ready == 1, "R4 out_ready on third edge", out_ready, 1);
    chk(dout == 4'hA, "R4 head word on third edge", dout, 4'hA);
    pull();
    chk(out_ready == 0, "R3 out_ready after last pop", out_ready, 0);
    chk(dout == 4'hA, "R5 dout holds last popped", dout, 4'hA);
    repeat (6) @(posedge wclk); #1;

    // exhaustive fill sweep with default offset
    for (int n = 1; n <= DEPTH; n++) begin
      push(pat(n), acc);
      chk(acc == 1, "R2 write accepted below full", acc, 1);
      chk(half_full == (n >= DEPTH/2), "R6 half_full vs occupancy", half_full, n >= DEPTH/2);
      chk(edge_flag == near(n, KDEF), "R7 edge_flag default offset", edge_flag, near(n, KDEF));
      chk(in_ready == (n < DEPTH), "R2 in_ready vs full", in_ready, n < DEPTH);
      if (n == 4) begin
        din = 4'hF; wen_a = 1; wen_b = 0;
        @(posedge wclk); #1;
        wen_a = 0;
        chk(edge_flag == near(4, KDEF), "R2 wen_b low blocks write", edge_flag, near(4, KDEF));
      end
    end
    push(4'h0, acc);
    chk(acc == 0, "R2 in_ready low when full", acc, 0);
    chk(half_full == 1, "R6 half_full when full", half_full, 1);

    // drain and check order, enable gating, cautious write-side view
    for (int i = 1; i <= DEPTH; i++) begin
      chk(out_ready == 1, "R3 out_ready with data", out_ready, 1);
      chk(dout == pat(i), "R1 order of words", dout, pat(i));
      if (i == 5) begin
        oe = 0; rd_a = 1;
        repeat (2) @(posedge rclk); #1;
        rd_a = 0; oe = 1; #1;
        chk(out_ready == 1 && dout == pat(i), "R5 oe low blocks pop", dout, pat(i));
      end
      if (i == 7) begin
        rd_b = 0; rd_a = 1;
        @(posedge rclk); #1;
        rd_a = 0; rd_b = 1;
        chk(dout == pat(i), "R3 rd_b low blocks pop", dout, pat(i));
      end
      pull();
      if (i == 1) begin
        @(posedge wclk); #1;
        chk(in_ready == 0, "R11 in_ready still low after pop", in_ready, 0);
        repeat (3) @(posedge wclk); #1;
        chk(in_ready == 1, "R11 in_ready recovered", in_ready, 1);
      end
    end
    repeat (3) @(posedge rclk); #1;
    chk(out_ready == 0, "R3 empty after drain", out_ready, 0);
    chk(dout == pat(DEPTH), "R5 last word held", dout, pat(DEPTH));
    repeat (6) @(posedge wclk); #1;
    chk(half_full == 0 && edge_flag == 1 && in_ready == 1, "R11 flags after drain",
        {half_full, edge_flag, in_ready}, 3'b011);

    // programmed offset 5, later reprogram attempt ignored
    do_reset(1'b0);
    program_ofs(1'b0, 4'd5);
    for (int n = 1; n <= 12; n++) begin
      push(pat(n), acc);
      chk(edge_flag == near(n, 5), "R10 edge_flag with offset 5", edge_flag, near(n, 5));
      chk(half_full == (n >= DEPTH/2), "R10 no write during load", half_full, n >= DEPTH/2);
      if (n == 1) begin
        prog_n = 0; wen_a = 1; wen_b = 1; din = 4'd0;
        @(posedge wclk); #1;
        prog_n = 1; wen_a = 0; wen_b = 0;
      end
    end

    // offset MSB taken from wen_a
    do_reset(1'b0);
    program_ofs(1'b1, 4'd0);
    for (int n = 1; n <= 8; n++) push(pat(n), acc);
    chk(edge_flag == 1, "R10 wen_a as offset MSB", edge_flag, 1);

    // asynchronous stress with a slower read clock
    do_reset(1'b0);
    rhalf = 3;
    repeat (4) @(posedge rclk);
    @(posedge wclk); #1;
    fork
      begin : writer
        for (int i = 0; i < 200; i++) begin
          bit ok;
          if (i % 5 == 2) begin repeat (3) @(posedge wclk); #1; end
          din = DW'(i * 7 + 3); wen_a = 1; wen_b = 1;
          do begin
            ok = in_ready;
            @(posedge wclk); #1;
          end while (!ok);
          wen_a = 0; wen_b = 0;
          mq.push_back(DW'(i * 7 + 3));
        end
      end
      begin : reader
        @(posedge rclk); #1;
        for (int j = 0; j < 200; j++) begin
          bit ok;
          logic [DW-1:0] d;
          logic [DW-1:0] e;
          if (j % 7 == 3) begin repeat (4) @(posedge rclk); #1; end
          rd_a = 1;
          do begin
            ok = out_ready;
            d = dout;
            @(posedge rclk); #1;
          end while (!ok);
          rd_a = 0;
          e = mq.pop_front();
          chk(d == e, "R1 async stream order", d, e);
        end
      end
    join
    repeat (4) @(posedge rclk); #1;
    chk(out_ready == 0, "R3 empty after stream", out_ready, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule